// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits beside the write engine of a small byte-wide nonvolatile memory. It watches qualified byte loads, each an address and a data byte, and recognises the multi-load command codes. These codes switch write protection on or off, enter or leave identification mode, and lock either of the two boot blocks against writing. It keeps the protect flag and the two lock flags in registers that only a power-on reset clears, so they behave as nonvolatile state. Identification mode and the sequence tracker clear on any reset.

The write engine marks the end of each load window with `win_close` and the end of the program period with `prog_done`. While protection is on, `store_ok` says whether the current window has been opened by the unlock prefix. When it is low, the engine still runs its timer and status polling but stores nothing. `ld_blocked` flags an address that falls in a locked boot block. `chip_erase_ok` drops once either block is locked. In identification mode, `id_rdata` gives the value a read of `rd_addr` should return.

Top module: `cmd_unlock_decoder`

## Requirements
- R1: A command step is matched on load address bits 14..0 and the full 8-bit data. Address bits 16..15 are ignored for these steps, so 15555 matches as 5555 and 0AAAA matches as 2AAA.
- R2: The three loads AA@5555, 55@2AAA, A0@5555 with protection off leave `store_ok` high and set `prot_on` at the next `prog_done` pulse, not before.
- R3: While `prot_on` is high, `store_ok` is low in a window that did not begin with AA@5555, 55@2AAA, A0@5555. It is high once that prefix has been loaded and returns low after `win_close`. `prot_on` stays set across `prog_done`.
- R4: The six loads AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 20@5555 raise `store_ok` for the window and clear `prot_on` at the next `prog_done` pulse, not before.
- R5: AA@5555, 55@2AAA, 90@5555 sets `id_mode` in the cycle after the last load. The same prefix ending in F0@5555 clears it.
- R6: In identification mode, `id_rdata` is 1F for `rd_addr` 00000, D5 for 00001 and 00 for other non-status addresses. Outside identification mode it is 00.
- R7: In identification mode, `rd_addr` 00002 returns the lower boot-block state and 1FFF2 the upper one. The value is FE when the block is unlocked and FF when it is locked.
- R8: The prefix AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 40@5555 followed by 00@00000 sets `lock_lo`. Followed by FF@1FFFF it sets `lock_hi`. Any other load after the prefix locks nothing. The lock flags never fall except on `por_n`.
- R9: `ld_blocked` is high for an `ld_addr` in 00000..01FFF while `lock_lo` is set, and for one in 1E000..1FFFF while `lock_hi` is set. It is low elsewhere. `chip_erase_ok` is low whenever either lock flag is set.
- R10: A load that does not match the expected next step abandons the sequence in progress. That same load is then checked as a first step, so AA@5555, AA@5555, 55@2AAA, 90@5555 still enters identification mode.
- R11: `win_close` abandons any partly loaded sequence.
- R12: `rst_n` clears identification mode, the tracker and the window unlock, but keeps `prot_on`, `lock_lo` and `lock_hi`. `por_n` clears everything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears persistent flags |
| rst_n | input | 1 | Functional reset, active low |
| ld_valid | input | 1 | One-cycle strobe of a qualified byte load |
| ld_addr | input | 17 | Load address |
| ld_data | input | 8 | Load data |
| win_close | input | 1 | Pulse: load window has ended |
| prog_done | input | 1 | Pulse: program period has ended |
| rd_addr | input | 17 | Read address for identification data |
| prot_on | output | 1 | Write protection active |
| lock_lo | output | 1 | Lower boot block locked |
| lock_hi | output | 1 | Upper boot block locked |
| id_mode | output | 1 | Identification mode active |
| store_ok | output | 1 | Current window may store data |
| ld_blocked | output | 1 | `ld_addr` lies in a locked boot block |
| chip_erase_ok | output | 1 | Whole-array erase permitted |
| id_rdata | output | 8 | Identification read value for `rd_addr` |

## Verification
The bench first aims at the delayed effect of the protect sequences. A decoder that changed `prot_on` on the last command load, rather than at `prog_done`, would be caught by the checks made between `win_close` and `prog_done`. It then repeats a first step and breaks off a sequence half way. A tracker that simply dropped to idle on a mismatch would miss the identification entry that follows, and one that ignored `win_close` would accept a sequence split across windows. The lock tests load a wrong address after the lockout prefix and probe the addresses just inside and just outside each 8K block, which exposes off-by-one boundaries and swapped status addresses. A closing pair of resets shows whether the flags were wrongly tied to the functional reset.

// File: rtl/cmd_unlock_pkg.sv
package cmd_unlock_pkg;

  // Width of the address slice used for command steps.
  localparam int CMD_AW = 15;

  localparam logic [CMD_AW-1:0] ADR_HI5 = 15'h5555;
  localparam logic [CMD_AW-1:0] ADR_LO2 = 15'h2AAA;

  localparam logic [7:0] D_KEY1    = 8'hAA;
  localparam logic [7:0] D_KEY2    = 8'h55;
  localparam logic [7:0] D_GUARD   = 8'hA0;
  localparam logic [7:0] D_IDIN    = 8'h90;
  localparam logic [7:0] D_IDOUT   = 8'hF0;
  localparam logic [7:0] D_EXTEND  = 8'h80;
  localparam logic [7:0] D_UNGUARD = 8'h20;
  localparam logic [7:0] D_LOCKSEL = 8'h40;
  localparam logic [7:0] D_LOCKLO  = 8'h00;
  localparam logic [7:0] D_LOCKHI  = 8'hFF;

  typedef enum logic [2:0] {
    TS_IDLE,   // nothing matched
    TS_K1,     // first key seen
    TS_K2,     // second key seen, waiting for the command byte
    TS_X1,     // extend byte seen
    TS_X2,     // first key of the extended part seen
    TS_X3,     // second key of the extended part seen
    TS_LSEL    // lockout prefix complete, waiting for block select
  } trk_state_t;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_GUARD,
    EV_UNGUARD,
    EV_ID_IN,
    EV_ID_OUT,
    EV_LOCK_LO,
    EV_LOCK_HI
  } cmd_event_t;

  // True when a load matches one command step (address slice and data).
  function automatic logic step_hit(input logic [CMD_AW-1:0] a,
                                    input logic [7:0] d,
                                    input logic [CMD_AW-1:0] ea,
                                    input logic [7:0] ed);
    return (a == ea) && (d == ed);
  endfunction

endpackage

// File: rtl/cmd_seq_tracker.sv
module cmd_seq_tracker
  import cmd_unlock_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              sys_rst_n,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        ld_data,
  input  logic              win_close,
  output cmd_event_t        ev,
  output trk_state_t        state
);

  localparam logic [ADDR_W-1:0] ADDR_TOP = {ADDR_W{1'b1}};

  trk_state_t nxt;
  cmd_event_t ev_raw;
  logic [CMD_AW-1:0] a_cmd;
  logic first_hit;

  assign a_cmd     = ld_addr[CMD_AW-1:0];
  assign first_hit = step_hit(a_cmd, ld_data, ADR_HI5, D_KEY1);

  always_comb begin
    ev_raw = EV_NONE;
    // a mismatch falls back to checking the load as a first step
    nxt    = first_hit ? TS_K1 : TS_IDLE;
    unique case (state)
      TS_IDLE: ;
      TS_K1: begin
        if (step_hit(a_cmd, ld_data, ADR_LO2, D_KEY2)) nxt = TS_K2;
      end
      TS_K2: begin
        if (a_cmd == ADR_HI5) begin
          unique case (ld_data)
            D_GUARD:  begin ev_raw = EV_GUARD;  nxt = TS_IDLE; end
            D_IDIN:   begin ev_raw = EV_ID_IN;  nxt = TS_IDLE; end
            D_IDOUT:  begin ev_raw = EV_ID_OUT; nxt = TS_IDLE; end
            D_EXTEND: nxt = TS_X1;
            default:  ;
          endcase
        end
      end
      TS_X1: ; // only the first key continues, same as the fallback
      TS_X2: begin
        if (step_hit(a_cmd, ld_data, ADR_LO2, D_KEY2)) nxt = TS_X3;
      end
      TS_X3: begin
        if (step_hit(a_cmd, ld_data, ADR_HI5, D_UNGUARD)) begin
          ev_raw = EV_UNGUARD; nxt = TS_IDLE;
        end else if (step_hit(a_cmd, ld_data, ADR_HI5, D_LOCKSEL)) begin
          nxt = TS_LSEL;
        end
      end
      TS_LSEL: begin
        if (ld_addr == '0 && ld_data == D_LOCKLO) begin
          ev_raw = EV_LOCK_LO; nxt = TS_IDLE;
        end else if (ld_addr == ADDR_TOP && ld_data == D_LOCKHI) begin
          ev_raw = EV_LOCK_HI; nxt = TS_IDLE;
        end
      end
      default: nxt = TS_IDLE;
    endcase
    if (state == TS_X1 && first_hit) nxt = TS_X2;
  end

  assign ev = (ld_valid && !win_close) ? ev_raw : EV_NONE;

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n)     state <= TS_IDLE;
    else if (win_close) state <= TS_IDLE;
    else if (ld_valid)  state <= nxt;
  end

endmodule

// File: rtl/cmd_prot_state.sv
module cmd_prot_state
  import cmd_unlock_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       sys_rst_n,
  input  cmd_event_t ev,
  input  logic       win_close,
  input  logic       prog_done,
  output logic       prot_on,
  output logic       lock_lo,
  output logic       lock_hi,
  output logic       id_mode,
  output logic       win_unlocked
);

  logic pend_on, pend_off;

  // Persistent flags: only the power-on reset clears them.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      prot_on <= 1'b0;
      lock_lo <= 1'b0;
      lock_hi <= 1'b0;
    end else begin
      if (prog_done) begin
        if (pend_off)     prot_on <= 1'b0;
        else if (pend_on) prot_on <= 1'b1;
      end
      if (ev == EV_LOCK_LO) lock_lo <= 1'b1;
      if (ev == EV_LOCK_HI) lock_hi <= 1'b1;
    end
  end

  // Session state: cleared by any reset.
  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      id_mode      <= 1'b0;
      win_unlocked <= 1'b0;
      pend_on      <= 1'b0;
      pend_off     <= 1'b0;
    end else begin
      if (ev == EV_ID_IN)  id_mode <= 1'b1;
      if (ev == EV_ID_OUT) id_mode <= 1'b0;
      if (win_close)
        win_unlocked <= 1'b0;
      else if (ev == EV_GUARD || ev == EV_UNGUARD)
        win_unlocked <= 1'b1;
      if (prog_done) begin
        pend_on  <= 1'b0;
        pend_off <= 1'b0;
      end else if (ev == EV_GUARD && !prot_on) begin
        pend_on  <= 1'b1;
        pend_off <= 1'b0;
      end else if (ev == EV_UNGUARD) begin
        pend_off <= 1'b1;
        pend_on  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cmd_id_readout.sv
module cmd_id_readout #(
  parameter int         ADDR_W   = 17,
  parameter logic [7:0] MFR_CODE = 8'h1F,
  parameter logic [7:0] DEV_CODE = 8'hD5
) (
  input  logic              id_mode,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              lock_lo,
  input  logic              lock_hi,
  output logic [7:0]        id_rdata
);

  localparam logic [ADDR_W-1:0] A_MFR   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DEV   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_LOSTS = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_HISTS = {{(ADDR_W-4){1'b1}}, 4'h2};

  function automatic logic [7:0] lock_code(input logic locked);
    return {7'h7F, locked};
  endfunction

  always_comb begin
    id_rdata = 8'h00;
    if (id_mode) begin
      if (rd_addr == A_MFR)        id_rdata = MFR_CODE;
      else if (rd_addr == A_DEV)   id_rdata = DEV_CODE;
      else if (rd_addr == A_LOSTS) id_rdata = lock_code(lock_lo);
      else if (rd_addr == A_HISTS) id_rdata = lock_code(lock_hi);
    end
  end

endmodule

// File: rtl/cmd_unlock_decoder.sv
module cmd_unlock_decoder
  import cmd_unlock_pkg::*;
#(
  parameter int         ADDR_W   = 17,
  parameter int         BOOT_W   = 13,
  parameter logic [7:0] MFR_CODE = 8'h1F,
  parameter logic [7:0] DEV_CODE = 8'hD5
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        ld_data,
  input  logic              win_close,
  input  logic              prog_done,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              prot_on,
  output logic              lock_lo,
  output logic              lock_hi,
  output logic              id_mode,
  output logic              store_ok,
  output logic              ld_blocked,
  output logic              chip_erase_ok,
  output logic [7:0]        id_rdata
);

  localparam int BLK_W = ADDR_W - BOOT_W;

  logic       sys_rst_n;
  cmd_event_t ev;
  trk_state_t trk_state;
  logic       win_unlocked;
  logic       in_lo_blk, in_hi_blk;

  assign sys_rst_n = rst_n & por_n;

  cmd_seq_tracker #(.ADDR_W(ADDR_W)) i_trk (
    .clk       (clk),
    .sys_rst_n (sys_rst_n),
    .ld_valid  (ld_valid),
    .ld_addr   (ld_addr),
    .ld_data   (ld_data),
    .win_close (win_close),
    .ev        (ev),
    .state     (trk_state)
  );

  cmd_prot_state i_st (
    .clk          (clk),
    .por_n        (por_n),
    .sys_rst_n    (sys_rst_n),
    .ev           (ev),
    .win_close    (win_close),
    .prog_done    (prog_done),
    .prot_on      (prot_on),
    .lock_lo      (lock_lo),
    .lock_hi      (lock_hi),
    .id_mode      (id_mode),
    .win_unlocked (win_unlocked)
  );

  cmd_id_readout #(.ADDR_W(ADDR_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) i_id (
    .id_mode  (id_mode),
    .rd_addr  (rd_addr),
    .lock_lo  (lock_lo),
    .lock_hi  (lock_hi),
    .id_rdata (id_rdata)
  );

  assign in_lo_blk     = (ld_addr[ADDR_W-1:BOOT_W] == {BLK_W{1'b0}});
  assign in_hi_blk     = (ld_addr[ADDR_W-1:BOOT_W] == {BLK_W{1'b1}});
  assign ld_blocked    = (lock_lo && in_lo_blk) || (lock_hi && in_hi_blk);
  assign chip_erase_ok = !(lock_lo || lock_hi);
  assign store_ok      = !prot_on || win_unlocked;

endmodule

// File: rtl/cmd_unlock_checker.sv
module cmd_unlock_checker #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              por_n,
  input logic              rst_n,
  input logic              ld_valid,
  input logic [7:0]        ld_data,
  input logic [ADDR_W-1:0] ld_addr,
  input logic              win_close,
  input logic              prog_done,
  input logic              prot_on,
  input logic              lock_lo,
  input logic              lock_hi,
  input logic              id_mode,
  input logic              store_ok
);

  a_r2_prot_set_at_done: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $rose(prot_on) |-> $past(prog_done));

  a_r4_prot_clr_at_done: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $fell(prot_on) |-> $past(prog_done));

  a_r3_window_relock: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (win_close && !prog_done) |=> (store_ok == !prot_on));

  a_r5_id_entry_cause: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $rose(id_mode) |-> ($past(ld_valid) && $past(ld_data) == 8'h90));

  a_r5_id_exit_cause: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $fell(id_mode) |-> ($past(ld_valid) && $past(ld_data) == 8'hF0));

  a_r8_lock_lo_sticky: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    !$fell(lock_lo));

  a_r8_lock_hi_sticky: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    !$fell(lock_hi));

  a_r8_lock_lo_cause: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $rose(lock_lo) |-> ($past(ld_valid) && $past(ld_data) == 8'h00 && $past(ld_addr) == '0));

  a_r8_lock_hi_cause: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $rose(lock_hi) |-> ($past(ld_valid) && $past(ld_data) == 8'hFF && $past(ld_addr) == '1));

endmodule

bind cmd_unlock_decoder cmd_unlock_checker #(.ADDR_W(ADDR_W)) i_chk (
  .clk       (clk),
  .por_n     (por_n),
  .rst_n     (rst_n),
  .ld_valid  (ld_valid),
  .ld_data   (ld_data),
  .ld_addr   (ld_addr),
  .win_close (win_close),
  .prog_done (prog_done),
  .prot_on   (prot_on),
  .lock_lo   (lock_lo),
  .lock_hi   (lock_hi),
  .id_mode   (id_mode),
  .store_ok  (store_ok)
);

// File: tb/test_cmd_unlock_decoder.sv
module test_cmd_unlock_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          por_n, rst_n, ld_valid, win_close, prog_done;
  logic [AW-1:0] ld_addr, rd_addr;
  logic [7:0]    ld_data;
  logic          prot_on, lock_lo, lock_hi, id_mode, store_ok, ld_blocked, chip_erase_ok;
  logic [7:0]    id_rdata;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_unlock_decoder i_cmd_unlock_decoder (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .ld_valid(ld_valid),
    .ld_addr(ld_addr), .ld_data(ld_data), .win_close(win_close),
    .prog_done(prog_done), .rd_addr(rd_addr), .prot_on(prot_on),
    .lock_lo(lock_lo), .lock_hi(lock_hi), .id_mode(id_mode),
    .store_ok(store_ok), .ld_blocked(ld_blocked),
    .chip_erase_ok(chip_erase_ok), .id_rdata(id_rdata)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", what, act, exp);
    end
  endtask

  task automatic load(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic pulse_close();
    @(negedge clk); win_close = 1'b1;
    @(negedge clk); win_close = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); prog_done = 1'b1;
    @(negedge clk); prog_done = 1'b0;
  endtask

  task automatic prefix3(input logic [7:0] cmd);
    load(17'h05555, 8'hAA); load(17'h02AAA, 8'h55); load(17'h05555, cmd);
  endtask

  task automatic prefix6(input logic [7:0] cmd);
    prefix3(8'h80);
    load(17'h05555, 8'hAA); load(17'h02AAA, 8'h55); load(17'h05555, cmd);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] exp, input string what);
    rd_addr = a; #1;
    chk(id_rdata, exp, what);
  endtask

  task automatic probe(input logic [AW-1:0] a, input logic exp, input string what);
    ld_addr = a; #1;
    chk({7'd0, ld_blocked}, {7'd0, exp}, what);
  endtask

  task automatic t_reset();
    chk({7'd0, prot_on}, 8'd0, "R12 por prot_on");
    chk({7'd0, lock_lo | lock_hi}, 8'd0, "R12 por locks");
    chk({7'd0, id_mode}, 8'd0, "R12 por id_mode");
    chk({7'd0, store_ok}, 8'd1, "R3 store_ok unprotected");
    chk({7'd0, chip_erase_ok}, 8'd1, "R9 erase ok at start");
    rd(17'h00000, 8'h00, "R6 no id data outside id mode");
  endtask

  task automatic t_id();
    // alias addresses with bit 15/16 set still match (R1)
    load(17'h15555, 8'hAA); load(17'h0AAAA, 8'h55); load(17'h05555, 8'h90);
    chk({7'd0, id_mode}, 8'd1, "R1 R5 id entry via alias addresses");
    rd(17'h00000, 8'h1F, "R6 maker code");
    rd(17'h00001, 8'hD5, "R6 device code");
    rd(17'h00005, 8'h00, "R6 other address");
    rd(17'h00002, 8'hFE, "R7 lower unlocked");
    rd(17'h1FFF2, 8'hFE, "R7 upper unlocked");
    prefix3(8'hF0);
    chk({7'd0, id_mode}, 8'd0, "R5 id exit");
    pulse_close();
  endtask

  task automatic t_restart();
    load(17'h05555, 8'hAA);
    prefix3(8'h90);
    chk({7'd0, id_mode}, 8'd1, "R10 repeated first step restarts");
    prefix3(8'hF0);
    load(17'h05555, 8'hAA); load(17'h02AAA, 8'h55); load(17'h05555, 8'h12);
    load(17'h05555, 8'h90);
    chk({7'd0, id_mode}, 8'd0, "R10 broken sequence ignored");
    load(17'h05555, 8'hAA); load(17'h02AAA, 8'h54);
    load(17'h02AAA, 8'h55); load(17'h05555, 8'h90);
    chk({7'd0, id_mode}, 8'd0, "R1 data byte must match exactly");
    pulse_close();
  endtask

  task automatic t_window();
    load(17'h05555, 8'hAA); load(17'h02AAA, 8'h55);
    pulse_close();
    load(17'h05555, 8'h90);
    chk({7'd0, id_mode}, 8'd0, "R11 win_close drops partial sequence");
    pulse_close();
  endtask

  task automatic t_enable();
    prefix3(8'hA0);
    load(17'h00100, 8'h12);
    chk({7'd0, store_ok}, 8'd1, "R2 enable window stores");
    pulse_close();
    chk({7'd0, prot_on}, 8'd0, "R2 not active before prog_done");
    pulse_done();
    chk({7'd0, prot_on}, 8'd1, "R2 active after prog_done");
    chk({7'd0, store_ok}, 8'd0, "R3 idle window closed");
  endtask

  task automatic t_guarded();
    load(17'h00180, 8'h34);
    chk({7'd0, store_ok}, 8'd0, "R3 no prefix no store");
    pulse_close(); pulse_done();
    chk({7'd0, prot_on}, 8'd1, "R3 prot holds");
    prefix3(8'hA0);
    chk({7'd0, store_ok}, 8'd1, "R3 prefix opens window");
    load(17'h00200, 8'h56);
    pulse_close();
    chk({7'd0, store_ok}, 8'd0, "R3 window relocks on close");
    pulse_done();
    chk({7'd0, prot_on}, 8'd1, "R3 prot stays after guarded write");
  endtask

  task automatic t_disable();
    prefix6(8'h20);
    chk({7'd0, store_ok}, 8'd1, "R4 disable window stores");
    pulse_close();
    chk({7'd0, prot_on}, 8'd1, "R4 still on before prog_done");
    pulse_done();
    chk({7'd0, prot_on}, 8'd0, "R4 off after prog_done");
    chk({7'd0, store_ok}, 8'd1, "R4 stores freely");
  endtask

  task automatic t_locks();
    prefix6(8'h40);
    load(17'h00001, 8'h00);
    chk({7'd0, lock_lo | lock_hi}, 8'd0, "R8 wrong select address locks nothing");
    pulse_close();
    prefix6(8'h40);
    load(17'h00000, 8'h00);
    chk({7'd0, lock_lo}, 8'd1, "R8 lower locked");
    chk({7'd0, lock_hi}, 8'd0, "R8 upper untouched");
    chk({7'd0, chip_erase_ok}, 8'd0, "R9 erase off after lock");
    probe(17'h01FFF, 1'b1, "R9 last byte of lower block");
    probe(17'h02000, 1'b0, "R9 first byte past lower block");
    probe(17'h1E000, 1'b0, "R9 upper block open");
    pulse_close();
    prefix3(8'h90);
    rd(17'h00002, 8'hFF, "R7 lower locked status");
    rd(17'h1FFF2, 8'hFE, "R7 upper unlocked status");
    prefix3(8'hF0);
    prefix6(8'h40);
    load(17'h1FFFF, 8'hFF);
    chk({7'd0, lock_hi}, 8'd1, "R8 upper locked");
    probe(17'h1E000, 1'b1, "R9 first byte of upper block");
    probe(17'h1DFFF, 1'b0, "R9 byte below upper block");
    pulse_close();
  endtask

  task automatic t_resets();
    prefix3(8'h90);
    load(17'h05555, 8'hAA); load(17'h02AAA, 8'h55);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk({7'd0, id_mode}, 8'd0, "R12 rst_n clears id mode");
    chk({7'd0, lock_lo & lock_hi}, 8'd1, "R12 rst_n keeps locks");
    load(17'h05555, 8'h90);
    chk({7'd0, id_mode}, 8'd0, "R12 rst_n clears tracker");
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    chk({7'd0, lock_lo | lock_hi}, 8'd0, "R12 por_n clears locks");
    chk({7'd0, chip_erase_ok}, 8'd1, "R12 erase ok after por");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    por_n = 1'b0; rst_n = 1'b0; ld_valid = 1'b0; win_close = 1'b0;
    prog_done = 1'b0; ld_addr = '0; ld_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_id();
    t_restart();
    t_window();
    t_enable();
    t_guarded();
    t_disable();
    t_locks();
    t_resets();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule